// File: doc/BRIEF.md
# Temperature Alert Polling Timer

This block decides when the memory controller should read the temperature status of the attached DRAM devices, and judges what comes back. It counts refresh-period ticks against a programmable interval. When the interval runs out, or when a low-power exit pulse arrives and exit polling is enabled, it issues a poll request to each enabled chip select in turn: chip select 0 first, then chip select 1. Each request is held until the reader answers with a response word that carries one temperature code per byte lane.

The block chooses the lanes to inspect from two settings: the number of lanes fitted with a monitoring device, and the device width. A wide device spans several lanes and reports only on its lowest lane. If any inspected code is above a programmable threshold, a sticky temperature alert bit is set in a small interrupt block. That block also holds a sticky command/address error bit, which an external error pulse sets. Each status bit is cleared by writing 1 to it. Separate set and clear strobes control the enables. The block provides the raw status, the masked status and a registered interrupt output.

Top module: `temp_poll_timer`

## Requirements
- R1: After a synchronous reset, `poll_req`, `irq`, `irq_raw`, `irq_en` and `irq_masked` are all 0, and the refresh-period count starts from zero.
- R2: With `cfg_interval` = N > 0, `poll_req` rises on the clock edge that samples the N-th `ref_tick` since reset or since the last poll start. An interval of 0 disables periodic polling.
- R3: A poll visits chip select 0 (`poll_cs` = 0) first when `cfg_cs0_en` is set, then chip select 1 (`poll_cs` = 1) when `cfg_cs1_en` is set. A disabled chip select is skipped, and with neither enabled no request is made.
- R4: `poll_req` stays high and `poll_cs` stays stable until the cycle in which `rsp_valid` is sampled high.
- R5: A `lp_exit` pulse starts a poll at once and restarts the refresh-period count when `cfg_lp_exit_en` is 1. When `cfg_lp_exit_en` is 0, the pulse has no effect.
- R6: A trigger that arrives while a poll is in progress is kept, and one further poll follows when the current poll ends.
- R7: Lane l's code is `rsp_data[8l+2:8l]`, and the other bits of each byte are ignored. Lane l is inspected only if l <= `cfg_lanes` and it is the lowest lane of a device. For `cfg_dev_width` 0, every lane is the lowest lane of a device. For 1, only even lanes are. For 2 or 3, only lane 0 is. An inspected code strictly greater than `cfg_thresh` sets `irq_raw[1]` (temperature alert) when the response is taken.
- R8: An `err_event` pulse sets `irq_raw[0]` (command/address error) on the next edge.
- R9: Raw status bits are sticky. A 1 on `stat_clr[b]` clears bit b, but a set event in the same cycle wins.
- R10: A 1 on `en_set[b]` sets `irq_en[b]`, and a 1 on `en_clr[b]` clears it. If both are 1 in the same cycle, the clear wins.
- R11: `irq_masked` = `irq_raw` AND `irq_en`. `irq` is high exactly when any masked bit is high, and it changes on the same edge as the status and enable bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_interval | input | 22 | Refresh periods between polls (0 = no periodic polls) |
| cfg_cs0_en | input | 1 | Poll chip select 0 |
| cfg_cs1_en | input | 1 | Poll chip select 1 |
| cfg_lp_exit_en | input | 1 | Poll on low-power exit |
| cfg_lanes | input | 2 | Highest lane index that has a monitoring device |
| cfg_dev_width | input | 2 | Device width: 0 one lane, 1 two lanes, 2/3 four lanes |
| cfg_thresh | input | 3 | Alert when a code exceeds this value |
| ref_tick | input | 1 | One pulse per refresh period |
| lp_exit | input | 1 | Pulse on exit from self-refresh or power-down |
| poll_req | output | 1 | Temperature read request |
| poll_cs | output | 1 | Target chip select of the request |
| rsp_valid | input | 1 | Response to the pending request |
| rsp_data | input | 32 | Per-lane temperature bytes |
| err_event | input | 1 | Command/address error pulse |
| stat_clr | input | 2 | Write-1-to-clear strobes for the status bits |
| en_set | input | 2 | Enable set strobes |
| en_clr | input | 2 | Enable clear strobes |
| irq_raw | output | 2 | Raw status: bit 1 temperature, bit 0 error |
| irq_en | output | 2 | Interrupt enables |
| irq_masked | output | 2 | Raw status AND enables |
| irq | output | 1 | Interrupt request |

## Verification
The hardest case to reach is a trigger that lands while a poll is still waiting for its response. It needs a slow responder and a second trigger timed inside that wait. The bench's responder therefore holds off for a programmable number of cycles and checks that the request and its target stay fixed during that time. A second low-power exit pulse is sent during the wait, and the scoreboard expects exactly one extra poll afterwards. Lane selection is driven with codes placed in lanes that the width and lane-count settings must exclude, and with codes equal to the threshold.

// File: rtl/tpt_pkg.sv
package tpt_pkg;
  typedef enum logic [0:0] {ST_IDLE, ST_WAIT} poll_st_e;
  localparam int IRQ_W    = 2;
  localparam int IRQ_ERR  = 0;
  localparam int IRQ_TEMP = 1;
endpackage

// File: rtl/tpt_interval.sv
module tpt_interval #(
  parameter int INT_W = 22
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [INT_W-1:0] cfg_interval,
  input  logic             cfg_lp_exit_en,
  input  logic             ref_tick,
  input  logic             lp_exit,
  output logic             trig
);
  logic [INT_W-1:0] cnt;
  logic [INT_W:0]   cnt_inc;
  logic             per_on;
  logic             trig_per;
  logic             trig_lp;

  assign per_on   = (cfg_interval != '0);
  assign cnt_inc  = {1'b0, cnt} + 1'b1;
  assign trig_per = ref_tick && per_on && (cnt_inc >= {1'b0, cfg_interval});
  assign trig_lp  = lp_exit && cfg_lp_exit_en;
  assign trig     = trig_per || trig_lp;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (trig) begin
      cnt <= '0;
    end else if (ref_tick && per_on) begin
      cnt <= cnt_inc[INT_W-1:0];
    end
  end
endmodule

// File: rtl/tpt_lane_eval.sv
module tpt_lane_eval #(
  parameter int LANES  = 4,
  parameter int LANE_W = 8,
  parameter int CODE_W = 3,
  parameter int LSEL_W = 2
) (
  input  logic [LANES*LANE_W-1:0] data,
  input  logic [LSEL_W-1:0]       cfg_lanes,
  input  logic [1:0]              cfg_dev_width,
  input  logic [CODE_W-1:0]       cfg_thresh,
  output logic                    alert
);
  logic [LANES-1:0] hot;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    localparam bit EVEN  = (l % 2) == 0;
    localparam bit FIRST = (l == 0);
    logic [CODE_W-1:0] code;
    logic in_range;
    logic in_dev;
    assign code     = data[l*LANE_W +: CODE_W];
    assign in_range = (LSEL_W'(l) <= cfg_lanes);
    assign in_dev   = (cfg_dev_width == 2'd0) ||
                      ((cfg_dev_width == 2'd1) && EVEN) ||
                      (cfg_dev_width[1] && FIRST);
    assign hot[l]   = in_range && in_dev && (code > cfg_thresh);
  end

  assign alert = |hot;
endmodule

// File: rtl/tpt_irq_regs.sv
module tpt_irq_regs #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] set_ev,
  input  logic [W-1:0] stat_clr,
  input  logic [W-1:0] en_set,
  input  logic [W-1:0] en_clr,
  output logic [W-1:0] raw,
  output logic [W-1:0] en,
  output logic         irq
);
  logic [W-1:0] raw_n;
  logic [W-1:0] en_n;

  always_comb begin
    raw_n = (raw & ~stat_clr) | set_ev;
    en_n  = (en | en_set) & ~en_clr;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      raw <= '0;
      en  <= '0;
      irq <= 1'b0;
    end else begin
      raw <= raw_n;
      en  <= en_n;
      irq <= |(raw_n & en_n);
    end
  end
endmodule

// File: rtl/temp_poll_timer.sv
module temp_poll_timer
  import tpt_pkg::*;
#(
  parameter int INT_W  = 22,
  parameter int LANES  = 4,
  parameter int LANE_W = 8,
  parameter int CODE_W = 3,
  parameter int LSEL_W = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [INT_W-1:0]        cfg_interval,
  input  logic                    cfg_cs0_en,
  input  logic                    cfg_cs1_en,
  input  logic                    cfg_lp_exit_en,
  input  logic [LSEL_W-1:0]       cfg_lanes,
  input  logic [1:0]              cfg_dev_width,
  input  logic [CODE_W-1:0]       cfg_thresh,
  input  logic                    ref_tick,
  input  logic                    lp_exit,
  output logic                    poll_req,
  output logic                    poll_cs,
  input  logic                    rsp_valid,
  input  logic [LANES*LANE_W-1:0] rsp_data,
  input  logic                    err_event,
  input  logic [IRQ_W-1:0]        stat_clr,
  input  logic [IRQ_W-1:0]        en_set,
  input  logic [IRQ_W-1:0]        en_clr,
  output logic [IRQ_W-1:0]        irq_raw,
  output logic [IRQ_W-1:0]        irq_en,
  output logic [IRQ_W-1:0]        irq_masked,
  output logic                    irq
);
  poll_st_e         st;
  logic             trig;
  logic             pend;
  logic             alert;
  logic             take;
  logic [IRQ_W-1:0] set_ev;

  tpt_interval #(.INT_W(INT_W)) u_interval (
    .clk            (clk),
    .rst            (rst),
    .cfg_interval   (cfg_interval),
    .cfg_lp_exit_en (cfg_lp_exit_en),
    .ref_tick       (ref_tick),
    .lp_exit        (lp_exit),
    .trig           (trig)
  );

  tpt_lane_eval #(
    .LANES(LANES), .LANE_W(LANE_W), .CODE_W(CODE_W), .LSEL_W(LSEL_W)
  ) u_lanes (
    .data          (rsp_data),
    .cfg_lanes     (cfg_lanes),
    .cfg_dev_width (cfg_dev_width),
    .cfg_thresh    (cfg_thresh),
    .alert         (alert)
  );

  assign take = (st == ST_WAIT) && rsp_valid;

  always_comb begin
    set_ev           = '0;
    set_ev[IRQ_ERR]  = err_event;
    set_ev[IRQ_TEMP] = take && alert;
  end

  tpt_irq_regs #(.W(IRQ_W)) u_irq (
    .clk      (clk),
    .rst      (rst),
    .set_ev   (set_ev),
    .stat_clr (stat_clr),
    .en_set   (en_set),
    .en_clr   (en_clr),
    .raw      (irq_raw),
    .en       (irq_en),
    .irq      (irq)
  );

  assign irq_masked = irq_raw & irq_en;

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_IDLE;
      poll_req <= 1'b0;
      poll_cs  <= 1'b0;
      pend     <= 1'b0;
    end else begin
      case (st)
        ST_IDLE: begin
          if (trig || pend) begin
            pend <= 1'b0;
            if (cfg_cs0_en) begin
              poll_req <= 1'b1;
              poll_cs  <= 1'b0;
              st       <= ST_WAIT;
            end else if (cfg_cs1_en) begin
              poll_req <= 1'b1;
              poll_cs  <= 1'b1;
              st       <= ST_WAIT;
            end
          end
        end
        default: begin
          if (trig) pend <= 1'b1;
          if (rsp_valid) begin
            if (!poll_cs && cfg_cs1_en) begin
              poll_cs <= 1'b1;
            end else begin
              poll_req <= 1'b0;
              st       <= ST_IDLE;
            end
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/temp_poll_timer_checker.sv
module temp_poll_timer_checker (
  input logic       clk,
  input logic       rst,
  input logic       cfg_cs0_en,
  input logic       cfg_cs1_en,
  input logic       poll_req,
  input logic       poll_cs,
  input logic       rsp_valid,
  input logic       err_event,
  input logic [1:0] stat_clr,
  input logic [1:0] en_set,
  input logic [1:0] en_clr,
  input logic [1:0] irq_raw,
  input logic [1:0] irq_en,
  input logic [1:0] irq_masked,
  input logic       irq
);
  assert_reset_quiet_R1: assert property (@(posedge clk)
    rst |=> (!poll_req && irq_raw == 2'b00 && irq_en == 2'b00 && !irq));

  assert_no_target_R3: assert property (@(posedge clk) disable iff (rst)
    (!cfg_cs0_en && !cfg_cs1_en && !poll_req) |=> !poll_req);

  assert_req_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (poll_req && !rsp_valid) |=> (poll_req && $stable(poll_cs)));

  assert_err_set_R8: assert property (@(posedge clk) disable iff (rst)
    err_event |=> irq_raw[0]);

  assert_temp_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    (irq_raw[1] && !stat_clr[1]) |=> irq_raw[1]);

  assert_en_set_R10: assert property (@(posedge clk) disable iff (rst)
    (en_set[0] && !en_clr[0]) |=> irq_en[0]);

  assert_en_clr_R10: assert property (@(posedge clk) disable iff (rst)
    en_clr[1] |=> !irq_en[1]);

  assert_irq_line_R11: assert property (@(posedge clk) disable iff (rst)
    irq == (|irq_masked));
endmodule

bind temp_poll_timer temp_poll_timer_checker u_chk (
  .clk        (clk),
  .rst        (rst),
  .cfg_cs0_en (cfg_cs0_en),
  .cfg_cs1_en (cfg_cs1_en),
  .poll_req   (poll_req),
  .poll_cs    (poll_cs),
  .rsp_valid  (rsp_valid),
  .err_event  (err_event),
  .stat_clr   (stat_clr),
  .en_set     (en_set),
  .en_clr     (en_clr),
  .irq_raw    (irq_raw),
  .irq_en     (irq_en),
  .irq_masked (irq_masked),
  .irq        (irq)
);

// File: tb/test_temp_poll_timer.sv
module test_temp_poll_timer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [21:0] cfg_interval = '0;
  logic        cfg_cs0_en = 1'b0, cfg_cs1_en = 1'b0, cfg_lp_exit_en = 1'b0;
  logic [1:0]  cfg_lanes = 2'd3, cfg_dev_width = 2'd0;
  logic [2:0]  cfg_thresh = 3'd3;
  logic        ref_tick = 1'b0, lp_exit = 1'b0;
  logic        poll_req, poll_cs;
  logic        rsp_valid = 1'b0;
  logic [31:0] rsp_data = '0;
  logic        err_event = 1'b0;
  logic [1:0]  stat_clr = '0, en_set = '0, en_clr = '0;
  logic [1:0]  irq_raw, irq_en, irq_masked;
  logic        irq;

  int errors = 0;
  int checks = 0;
  int rsp_delay = 0;
  logic        exp_cs_q[$];
  logic [31:0] data_q[$];

  always #5 clk = ~clk;

  temp_poll_timer i_temp_poll_timer (
    .clk(clk), .rst(rst), .cfg_interval(cfg_interval),
    .cfg_cs0_en(cfg_cs0_en), .cfg_cs1_en(cfg_cs1_en),
    .cfg_lp_exit_en(cfg_lp_exit_en), .cfg_lanes(cfg_lanes),
    .cfg_dev_width(cfg_dev_width), .cfg_thresh(cfg_thresh),
    .ref_tick(ref_tick), .lp_exit(lp_exit),
    .poll_req(poll_req), .poll_cs(poll_cs),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .err_event(err_event), .stat_clr(stat_clr),
    .en_set(en_set), .en_clr(en_clr),
    .irq_raw(irq_raw), .irq_en(irq_en), .irq_masked(irq_masked), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // driver side: expected poll targets and the data each one returns
  task automatic expect_poll(input logic cs, input logic [31:0] d);
    exp_cs_q.push_back(cs);
    data_q.push_back(d);
  endtask

  // monitor / responder: pops expectations as requests appear
  initial begin
    forever begin
      @(negedge clk);
      if (!rst && poll_req) begin
        logic got_cs;
        logic [31:0] d;
        got_cs = poll_cs;
        if (exp_cs_q.size() == 0) begin
          check("R3 unexpected poll", 32'(got_cs), 32'hEE);
          d = '0;
        end else begin
          check("R3 poll target", 32'(got_cs), 32'(exp_cs_q.pop_front()));
          d = data_q.pop_front();
        end
        for (int i = 0; i < rsp_delay; i++) begin
          @(negedge clk);
          check("R4 request held", {30'd0, poll_req, poll_cs}, {30'd0, 1'b1, got_cs});
        end
        rsp_data  = d;
        rsp_valid = 1'b1;
        @(negedge clk);
        rsp_valid = 1'b0;
      end
    end
  end

  task automatic tick();
    @(negedge clk); ref_tick = 1'b1;
    @(negedge clk); ref_tick = 1'b0;
    #1;
  endtask

  task automatic lp_pulse();
    @(negedge clk); lp_exit = 1'b1;
    @(negedge clk); lp_exit = 1'b0;
    #1;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic alert_case(input string req, input logic [31:0] d, input logic exp);
    expect_poll(1'b0, d);
    lp_pulse();
    idle(6);
    check(req, 32'(irq_raw[1]), 32'(exp));
    @(negedge clk); stat_clr = 2'b10;
    @(negedge clk); stat_clr = 2'b00;
    #1;
    check("R9 alert cleared", 32'(irq_raw[1]), 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    // R1 reset state
    check("R1 req", 32'(poll_req), 32'd0);
    check("R1 raw", 32'(irq_raw), 32'd0);
    check("R1 en/irq", {29'd0, irq_en, irq}, 32'd0);

    // R2 periodic polling, interval 3, chip select 0 only
    cfg_cs0_en = 1'b1; cfg_interval = 22'd3;
    tick(); tick();
    check("R2 no poll before interval", 32'(poll_req), 32'd0);
    expect_poll(1'b0, 32'h0);
    tick();
    check("R2 poll on third tick", 32'(poll_req), 32'd1);
    idle(4);
    tick(); tick();
    check("R2 count restarted", 32'(poll_req), 32'd0);
    expect_poll(1'b0, 32'h0);
    tick();
    check("R2 second period", 32'(poll_req), 32'd1);
    idle(4);
    cfg_interval = 22'd0;
    tick(); tick(); tick(); tick();
    check("R2 interval zero disables", 32'(poll_req), 32'd0);

    // R5 low-power exit ignored when disabled
    lp_pulse();
    idle(2);
    check("R5 exit ignored", 32'(poll_req), 32'd0);

    // R3 ordering across chip selects
    cfg_lp_exit_en = 1'b1; cfg_cs1_en = 1'b1;
    expect_poll(1'b0, 32'h0); expect_poll(1'b1, 32'h0);
    lp_pulse();
    idle(8);
    cfg_cs0_en = 1'b0;
    expect_poll(1'b1, 32'h0);
    lp_pulse();
    idle(6);
    cfg_cs1_en = 1'b0;
    lp_pulse();
    idle(4);
    check("R3 none enabled", 32'(poll_req), 32'd0);
    check("R3 all polls served", exp_cs_q.size(), 32'd0);

    // R5 exit restarts the count
    cfg_cs0_en = 1'b1; cfg_interval = 22'd3;
    tick(); tick();
    expect_poll(1'b0, 32'h0);
    lp_pulse();
    check("R5 exit poll", 32'(poll_req), 32'd1);
    idle(4);
    tick(); tick();
    check("R5 count restarted", 32'(poll_req), 32'd0);
    expect_poll(1'b0, 32'h0);
    tick();
    check("R5 period after exit", 32'(poll_req), 32'd1);
    idle(4);
    cfg_interval = 22'd0;

    // R4/R6 slow response with a trigger during the wait
    rsp_delay = 4;
    expect_poll(1'b0, 32'h0); expect_poll(1'b0, 32'h0);
    lp_pulse();
    lp_pulse();
    idle(16);
    check("R6 pending poll served", exp_cs_q.size(), 32'd0);
    check("R6 idle afterwards", 32'(poll_req), 32'd0);
    rsp_delay = 0;

    // R7 lane selection and threshold
    cfg_thresh = 3'd3; cfg_lanes = 2'd3; cfg_dev_width = 2'd0;
    alert_case("R7 lane2 above", 32'h0004_0000, 1'b1);
    alert_case("R7 equal not alert", 32'h0303_0303, 1'b0);
    alert_case("R7 upper bits ignored", 32'hF8F8_F8F8, 1'b0);
    cfg_lanes = 2'd1;
    alert_case("R7 lane beyond count", 32'h0007_0000, 1'b0);
    cfg_lanes = 2'd3; cfg_dev_width = 2'd1;
    alert_case("R7 odd lane x16", 32'h0700_0700, 1'b0);
    alert_case("R7 even lane x16", 32'h0007_0000, 1'b1);
    cfg_dev_width = 2'd2;
    alert_case("R7 lane2 x32", 32'h0007_0000, 1'b0);
    alert_case("R7 lane0 x32", 32'h0000_0007, 1'b1);

    // R8..R11 interrupt block
    @(negedge clk); err_event = 1'b1;
    @(negedge clk); err_event = 1'b0; #1;
    check("R8 error set", 32'(irq_raw), 32'h1);
    check("R11 masked off", {30'd0, irq_masked[0], irq}, 32'd0);
    @(negedge clk); en_set = 2'b01;
    @(negedge clk); en_set = 2'b00; #1;
    check("R10 enable set", 32'(irq_en), 32'h1);
    check("R11 irq on", {30'd0, irq_masked[0], irq}, 32'h3);
    @(negedge clk); stat_clr = 2'b01;
    @(negedge clk); stat_clr = 2'b00; #1;
    check("R9 clear", {29'd0, irq_raw, irq}, 32'd0);
    @(negedge clk); stat_clr = 2'b01; err_event = 1'b1;
    @(negedge clk); stat_clr = 2'b00; err_event = 1'b0; #1;
    check("R9 set wins", 32'(irq_raw[0]), 32'd1);
    @(negedge clk); en_set = 2'b01; en_clr = 2'b01;
    @(negedge clk); en_set = 2'b00; en_clr = 2'b00; #1;
    check("R10 clear wins", {29'd0, irq_en, irq}, 32'd0);
    @(negedge clk); en_set = 2'b10;
    @(negedge clk); en_set = 2'b00; #1;
    expect_poll(1'b0, 32'h0000_0007);
    lp_pulse();
    idle(6);
    check("R11 temp irq", {29'd0, irq_masked, irq}, 32'b101);
    @(negedge clk); en_clr = 2'b10;
    @(negedge clk); en_clr = 2'b00; #1;
    check("R10 enable cleared", {29'd0, irq_en, irq}, 32'd0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #1000000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule